// File: doc/BRIEF.md
# 64-bit Event Timer with Self-Rearming Comparator

This block keeps a 64-bit up-counter and a single 64-bit compare value, both reached through a narrow register port of `DATA_W` (32) bits. Software loads the counter one half at a time, sets a run bit, and programs the compare value the same way. When the compare unit is enabled and the count reaches the compare value, a pending flag is raised. In the self-rearming mode, each hit also adds a programmed step to the compare value, which gives a periodic event stream with no further software writes. The interrupt line is the pending flag gated by an enable bit. Software clears the flag by writing a one to it.

Writes to the counter halves, the control word, the compare halves and the step register pass through a fixed delay line of `SYNC_DLY` cycles before they take effect. This models a slow timer domain behind the bus. As each such write lands, a sticky completion bit is set. Software polls that bit and clears it by writing one. The enable, pending-flag and completion-bit writes act at once.

Top module: `gtmr_top`

## Requirements
- R1: While rst_n is low and after it rises, every register reads zero and irq is low.
- R2: Word addresses are: 0 count low, 1 count high, 2 control, 3 compare low, 4 compare high, 5 step, 6 interrupt enable, 7 pending flag, 8 main write-status, 9 count write-status; other addresses read zero. A write to addresses 0 to 5 changes its register exactly SYNC_DLY (default 3) rising edges after the edge that accepts it, and reads return the old value until then.
- R3: Control bit 0 is run. While it is set, the 64-bit count rises by one per cycle and carries from the low half into the high half. While it is clear, the count holds. A landing half-load replaces that half, keeps the other half and skips the increment in that cycle.
- R4: When a delayed write lands, it sets its completion bit. In the main write-status register these are bit 16 for control, bit 0 for compare low, bit 1 for compare high and bit 2 for step. In the count write-status register they are bit 0 for low and bit 1 for high.
- R5: Completion bits are sticky. Writing 1 to a bit position at address 8 or 9 clears that bit on the accepting edge, and writing 0 leaves it. A set on the same edge wins over a clear.
- R6: Control bit 1 enables compare. When it is set and the count equals the compare value, bit 0 of the pending flag is set on the next edge, whatever the enable. Without self-rearming, the compare value is left as it was.
- R7: With control bit 2 set, each hit adds the step (zero-extended) to the compare value on the same edge. A compare-half load landing in that cycle takes priority.
- R8: irq equals pending bit 0 AND enable bit 0. A write to the enable acts on its accepting edge. Writing 1 to bit 0 at address 7 clears the pending flag on the accepting edge, unless a hit sets it in that same cycle.
- R9: While control bit 1 is clear, the pending flag never becomes set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | DATA_W | Read data, combinational from rd_addr |
| irq | output | 1 | Level interrupt |

## Verification
A fault in the count, the compare value or the delay line shows on rd_data in the first cycle the reference model's value differs, because the bench reads a rotating address every cycle. A fault therefore appears within about ten cycles on any register. A lost or wrong compare hit shows on irq and on the pending flag one edge after the count passes the compare value. A fault in the self-rearming add shows as a compare value that is off the start-plus-multiple-of-step grid. Completion bits that are sticky in the wrong way, or that land at the wrong time, show up when addresses 8 and 9 are polled right after the delay has expired.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
   // word addresses; 0..5 are the delayed registers and must stay contiguous
   localparam int unsigned RA_CNT_LO = 0;
   localparam int unsigned RA_CNT_HI = 1;
   localparam int unsigned RA_CTRL   = 2;
   localparam int unsigned RA_CMP_LO = 3;
   localparam int unsigned RA_CMP_HI = 4;
   localparam int unsigned RA_STEP   = 5;
   localparam int unsigned RA_IRQ_EN = 6;
   localparam int unsigned RA_IRQ_ST = 7;
   localparam int unsigned RA_WS_MAIN = 8;
   localparam int unsigned RA_WS_CNT  = 9;

   // control bits
   localparam int unsigned CT_RUN    = 0;
   localparam int unsigned CT_CMP_EN = 1;
   localparam int unsigned CT_AUTO   = 2;
   localparam int unsigned CT_W      = 3;

   // main write-status bit positions
   localparam int unsigned WS_CMP_LO = 0;
   localparam int unsigned WS_CMP_HI = 1;
   localparam int unsigned WS_STEP   = 2;
   localparam int unsigned WS_CTRL   = 16;
endpackage

// File: rtl/gtmr_wrpipe.sv
module gtmr_wrpipe #(
   parameter int unsigned DEPTH = 3,
   parameter int unsigned W     = 36
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_vld,
   input  logic [W-1:0] in_bits,
   output logic         out_vld,
   output logic [W-1:0] out_bits
);
   logic [DEPTH-1:0] vld_q;
   logic [W-1:0]     bits_q [DEPTH];

   generate
      if (DEPTH == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q[0]  <= 1'b0;
               bits_q[0] <= '0;
            end else begin
               vld_q[0]  <= in_vld;
               bits_q[0] <= in_bits;
            end
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q <= '0;
               for (int i = 0; i < DEPTH; i++) bits_q[i] <= '0;
            end else begin
               vld_q     <= {vld_q[DEPTH-2:0], in_vld};
               bits_q[0] <= in_bits;
               for (int i = 1; i < DEPTH; i++) bits_q[i] <= bits_q[i-1];
            end
         end
      end
   endgenerate

   assign out_vld  = vld_q[DEPTH-1];
   assign out_bits = bits_q[DEPTH-1];
endmodule

// File: rtl/gtmr_count.sv
module gtmr_count #(
   parameter int unsigned CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             ld_lo,
   input  logic             ld_hi,
   input  logic [CNT_W/2-1:0] ld_data,
   output logic [CNT_W-1:0] cnt
);
   localparam int unsigned HALF = CNT_W / 2;

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (ld_lo)  cnt_q <= {cnt_q[CNT_W-1:HALF], ld_data};
      else if (ld_hi)  cnt_q <= {ld_data, cnt_q[HALF-1:0]};
      else if (run)    cnt_q <= cnt_q + CNT_W'(1);
   end

   assign cnt = cnt_q;

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !ld_lo && !ld_hi) |=> $stable(cnt_q));
   assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !ld_lo && !ld_hi) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/gtmr_cmp.sv
module gtmr_cmp #(
   parameter int unsigned CNT_W = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CNT_W-1:0]   cnt,
   input  logic               en,
   input  logic               auto_inc,
   input  logic               ld_lo,
   input  logic               ld_hi,
   input  logic               ld_step,
   input  logic [CNT_W/2-1:0] ld_data,
   output logic [CNT_W-1:0]   cmp,
   output logic [CNT_W/2-1:0] step,
   output logic               match
);
   localparam int unsigned HALF = CNT_W / 2;

   logic [CNT_W-1:0] cmp_q;
   logic [HALF-1:0]  step_q;

   assign match = en && (cnt == cmp_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cmp_q <= '0;
      else if (ld_lo)            cmp_q <= {cmp_q[CNT_W-1:HALF], ld_data};
      else if (ld_hi)            cmp_q <= {ld_data, cmp_q[HALF-1:0]};
      else if (match && auto_inc) cmp_q <= cmp_q + {{HALF{1'b0}}, step_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       step_q <= '0;
      else if (ld_step) step_q <= ld_data;
   end

   assign cmp  = cmp_q;
   assign step = step_q;

   assert_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (match && auto_inc && !ld_lo && !ld_hi) |=>
      (cmp_q == $past(cmp_q) + {{HALF{1'b0}}, $past(step_q)}));
   assert_oneshot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!auto_inc && !ld_lo && !ld_hi) |=> $stable(cmp_q));
endmodule

// File: rtl/gtmr_top.sv
module gtmr_top
   import gtmr_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned SYNC_DLY = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq
);
   localparam int unsigned CNT_W = 2 * DATA_W;
   localparam int unsigned REQ_W = ADDR_W + DATA_W;

   localparam logic [ADDR_W-1:0] AD_CNT_LO  = ADDR_W'(RA_CNT_LO);
   localparam logic [ADDR_W-1:0] AD_CNT_HI  = ADDR_W'(RA_CNT_HI);
   localparam logic [ADDR_W-1:0] AD_CTRL    = ADDR_W'(RA_CTRL);
   localparam logic [ADDR_W-1:0] AD_CMP_LO  = ADDR_W'(RA_CMP_LO);
   localparam logic [ADDR_W-1:0] AD_CMP_HI  = ADDR_W'(RA_CMP_HI);
   localparam logic [ADDR_W-1:0] AD_STEP    = ADDR_W'(RA_STEP);
   localparam logic [ADDR_W-1:0] AD_IRQ_EN  = ADDR_W'(RA_IRQ_EN);
   localparam logic [ADDR_W-1:0] AD_IRQ_ST  = ADDR_W'(RA_IRQ_ST);
   localparam logic [ADDR_W-1:0] AD_WS_MAIN = ADDR_W'(RA_WS_MAIN);
   localparam logic [ADDR_W-1:0] AD_WS_CNT  = ADDR_W'(RA_WS_CNT);

   // elaboration checks
   if (DATA_W < WS_CTRL + 1) begin : g_bad_data_w
      $error("gtmr_top: DATA_W must hold write-status bit %0d", WS_CTRL);
   end
   if (ADDR_W < 4) begin : g_bad_addr_w
      $error("gtmr_top: ADDR_W must be at least 4");
   end
   if (SYNC_DLY < 1) begin : g_bad_dly
      $error("gtmr_top: SYNC_DLY must be at least 1");
   end

   // ---------------- delayed write path ----------------
   logic              dly_req;
   logic              ap_vld;
   logic [REQ_W-1:0]  ap_bits;
   logic [ADDR_W-1:0] ap_addr;
   logic [DATA_W-1:0] ap_data;

   assign dly_req = wr_en && (wr_addr <= AD_STEP);

   gtmr_wrpipe #(.DEPTH(SYNC_DLY), .W(REQ_W)) u_pipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (dly_req),
      .in_bits  ({wr_addr, wr_data}),
      .out_vld  (ap_vld),
      .out_bits (ap_bits)
   );

   assign ap_addr = ap_bits[REQ_W-1:DATA_W];
   assign ap_data = ap_bits[DATA_W-1:0];

   logic ap_cnt_lo, ap_cnt_hi, ap_ctrl, ap_cmp_lo, ap_cmp_hi, ap_step;
   assign ap_cnt_lo = ap_vld && (ap_addr == AD_CNT_LO);
   assign ap_cnt_hi = ap_vld && (ap_addr == AD_CNT_HI);
   assign ap_ctrl   = ap_vld && (ap_addr == AD_CTRL);
   assign ap_cmp_lo = ap_vld && (ap_addr == AD_CMP_LO);
   assign ap_cmp_hi = ap_vld && (ap_addr == AD_CMP_HI);
   assign ap_step   = ap_vld && (ap_addr == AD_STEP);

   // ---------------- control ----------------
   logic [CT_W-1:0] ctrl_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (ap_ctrl) ctrl_q <= ap_data[CT_W-1:0];
   end

   // ---------------- counter and comparator ----------------
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  cmp;
   logic [DATA_W-1:0] step;
   logic              match;

   gtmr_count #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctrl_q[CT_RUN]),
      .ld_lo   (ap_cnt_lo),
      .ld_hi   (ap_cnt_hi),
      .ld_data (ap_data),
      .cnt     (cnt)
   );

   gtmr_cmp #(.CNT_W(CNT_W)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt      (cnt),
      .en       (ctrl_q[CT_CMP_EN]),
      .auto_inc (ctrl_q[CT_AUTO]),
      .ld_lo    (ap_cmp_lo),
      .ld_hi    (ap_cmp_hi),
      .ld_step  (ap_step),
      .ld_data  (ap_data),
      .cmp      (cmp),
      .step     (step),
      .match    (match)
   );

   // ---------------- write-status (sticky) ----------------
   // main: [0] cmp lo, [1] cmp hi, [2] step, [3] control (reads at bit WS_CTRL)
   logic [3:0] wsm_q, wsm_set, wsm_clr;
   logic [1:0] wsc_q, wsc_set, wsc_clr;
   logic       clr_main, clr_cnt;

   assign clr_main = wr_en && (wr_addr == AD_WS_MAIN);
   assign clr_cnt  = wr_en && (wr_addr == AD_WS_CNT);
   assign wsm_set  = {ap_ctrl, ap_step, ap_cmp_hi, ap_cmp_lo};
   assign wsm_clr  = clr_main ? {wr_data[WS_CTRL], wr_data[WS_STEP],
                                 wr_data[WS_CMP_HI], wr_data[WS_CMP_LO]} : 4'b0;
   assign wsc_set  = {ap_cnt_hi, ap_cnt_lo};
   assign wsc_clr  = clr_cnt ? wr_data[1:0] : 2'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wsm_q <= '0;
         wsc_q <= '0;
      end else begin
         wsm_q <= (wsm_q & ~wsm_clr) | wsm_set;
         wsc_q <= (wsc_q & ~wsc_clr) | wsc_set;
      end
   end

   // ---------------- interrupt ----------------
   logic irq_en_q, irq_st_q, st_clr;
   assign st_clr = wr_en && (wr_addr == AD_IRQ_ST) && wr_data[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_en_q <= 1'b0;
         irq_st_q <= 1'b0;
      end else begin
         if (wr_en && (wr_addr == AD_IRQ_EN)) irq_en_q <= wr_data[0];
         if (match)       irq_st_q <= 1'b1;
         else if (st_clr) irq_st_q <= 1'b0;
      end
   end

   assign irq = irq_st_q & irq_en_q;

   // ---------------- read mux ----------------
   always_comb begin
      rd_data = '0;
      unique case (rd_addr)
         AD_CNT_LO:  rd_data = cnt[DATA_W-1:0];
         AD_CNT_HI:  rd_data = cnt[CNT_W-1:DATA_W];
         AD_CTRL:    rd_data[CT_W-1:0] = ctrl_q;
         AD_CMP_LO:  rd_data = cmp[DATA_W-1:0];
         AD_CMP_HI:  rd_data = cmp[CNT_W-1:DATA_W];
         AD_STEP:    rd_data = step;
         AD_IRQ_EN:  rd_data[0] = irq_en_q;
         AD_IRQ_ST:  rd_data[0] = irq_st_q;
         AD_WS_MAIN: begin
            rd_data[WS_CMP_LO] = wsm_q[0];
            rd_data[WS_CMP_HI] = wsm_q[1];
            rd_data[WS_STEP]   = wsm_q[2];
            rd_data[WS_CTRL]   = wsm_q[3];
         end
         AD_WS_CNT:  rd_data[1:0] = wsc_q;
         default:    rd_data = '0;
      endcase
   end

   // ---------------- assertions ----------------
   assert_ctrl_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ap_ctrl |=> wsm_q[3]);
   assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_main |=> ((wsm_q & $past(wsm_q)) == $past(wsm_q)));
   assert_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      match |=> irq_st_q);
   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_clr && !match) |=> !irq_st_q);
   assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[CT_CMP_EN] && !irq_st_q && !st_clr) |=> !irq_st_q);
endmodule

// File: tb/sim_gtmr_top.sv
`timescale 1ns/1ps
module sim_gtmr_top;
   localparam int DLY = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   gtmr_top #(.DATA_W(32), .ADDR_W(4), .SYNC_DLY(DLY)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
   );

   // ---------------- behavioural reference ----------------
   typedef struct { int due; logic [3:0] a; logic [31:0] d; } pend_t;
   pend_t pq[$];
   pend_t pw;
   int          cyc;
   logic [63:0] m_cnt, m_cmp, n_cnt, n_cmp;
   logic [31:0] m_step, m_wsm;
   logic [2:0]  m_ctrl;
   logic [1:0]  m_wsc;
   logic        m_en, m_st, m_hit, m_ap;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_cmp = 0; m_step = 0; m_wsm = 0; m_ctrl = 0;
         m_wsc = 0; m_en = 0; m_st = 0; cyc = 0; pq.delete();
      end else begin
         m_hit = m_ctrl[1] && (m_cnt == m_cmp);
         m_ap = 0;
         if (pq.size() > 0 && pq[0].due == cyc) begin
            pw = pq.pop_front();
            m_ap = 1;
         end
         n_cnt = m_ctrl[0] ? m_cnt + 64'd1 : m_cnt;
         n_cmp = (m_hit && m_ctrl[2]) ? m_cmp + {32'd0, m_step} : m_cmp;
         if (wr_en && wr_addr == 8) m_wsm = m_wsm & ~(wr_data & 32'h0001_0007);
         if (wr_en && wr_addr == 9) m_wsc = m_wsc & ~wr_data[1:0];
         if (m_ap) begin
            case (pw.a)
               0: begin n_cnt = {m_cnt[63:32], pw.d}; m_wsc[0] = 1; end
               1: begin n_cnt = {pw.d, m_cnt[31:0]}; m_wsc[1] = 1; end
               2: begin m_ctrl = pw.d[2:0]; m_wsm[16] = 1; end
               3: begin n_cmp = {m_cmp[63:32], pw.d}; m_wsm[0] = 1; end
               4: begin n_cmp = {pw.d, m_cmp[31:0]}; m_wsm[1] = 1; end
               default: begin m_step = pw.d; m_wsm[2] = 1; end
            endcase
         end
         m_cnt = n_cnt;
         m_cmp = n_cmp;
         if (wr_en && wr_addr == 6) m_en = wr_data[0];
         if (m_hit) m_st = 1;
         else if (wr_en && wr_addr == 7 && wr_data[0]) m_st = 0;
         if (wr_en && wr_addr <= 5) begin
            pw.due = cyc + DLY; pw.a = wr_addr; pw.d = wr_data;
            pq.push_back(pw);
         end
         cyc++;
      end
   end

   function automatic logic [31:0] m_read(logic [3:0] a);
      case (a)
         0: return m_cnt[31:0];
         1: return m_cnt[63:32];
         2: return {29'd0, m_ctrl};
         3: return m_cmp[31:0];
         4: return m_cmp[63:32];
         5: return m_step;
         6: return {31'd0, m_en};
         7: return {31'd0, m_st};
         8: return m_wsm;
         9: return {30'd0, m_wsc};
         default: return 32'd0;
      endcase
   endfunction

   function automatic string tag_of(logic [3:0] a);
      case (a)
         0, 1: return "R3";
         2, 3, 4, 5: return "R2";
         6, 7: return "R8";
         8, 9: return "R4";
         default: return "R2";
      endcase
   endfunction

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(tag_of(rd_addr), {32'd0, rd_data}, {32'd0, m_read(rd_addr)});
         chk("R8", {63'd0, irq}, {63'd0, m_st & m_en});
      end
   end

   // ---------------- stimulus helpers (all start at posedge+2) ----------------
   task automatic wr(int a, logic [31:0] d);
      wr_en = 1; wr_addr = 4'(a); wr_data = d;
      @(posedge clk); #2;
      wr_en = 0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         rd_addr = (rd_addr == 4'd10) ? 4'd0 : rd_addr + 4'd1;
         @(posedge clk); #2;
      end
   endtask

   task automatic rdchk(int a, logic [31:0] exp, string tag);
      rd_addr = 4'(a);
      #8 chk(tag, {32'd0, rd_data}, {32'd0, exp});
      @(posedge clk); #2;
   endtask

   task automatic finish_run();
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   int n_clr;
   logic [31:0] v;

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      @(posedge clk); #2;
      // R1: reset values
      for (int a = 0; a < 11; a++) rdchk(a, 32'd0, "R1");
      chk("R1", {63'd0, irq}, 64'd0);

      // R2: landing time of a delayed write
      wr(0, 32'hFFFF_FFF0);
      rdchk(0, 32'd0, "R2");
      rdchk(0, 32'd0, "R2");
      rdchk(0, 32'd0, "R2");
      rdchk(0, 32'hFFFF_FFF0, "R2");
      wr(1, 32'd5);
      idle(5);
      rdchk(1, 32'd5, "R2");
      rdchk(9, 32'd3, "R4");

      // R3: run, carry into the high half, then hold
      wr(2, 32'd1);
      idle(40);
      rdchk(1, 32'd6, "R3");
      wr(2, 32'd0);
      idle(5);
      rd_addr = 0; #8 v = rd_data; @(posedge clk); #2;
      idle(10);
      rdchk(0, v, "R3");

      // R4/R5: sticky completion bits
      rdchk(8, 32'h0001_0000, "R4");
      wr(8, 32'd0);
      rdchk(8, 32'h0001_0000, "R5");
      wr(9, 32'd1);
      rdchk(9, 32'd2, "R5");
      wr(8, 32'h0001_0000);
      rdchk(8, 32'd0, "R5");

      // R6/R8: one-shot hit with interrupt masked, then unmasked, then cleared
      wr(0, 32'd0); wr(1, 32'd0); wr(3, 32'd100); wr(4, 32'd0);
      wr(2, 32'd3);
      idle(130);
      rdchk(7, 32'd1, "R6");
      chk("R6", {63'd0, irq}, 64'd0);
      rdchk(8, 32'h0001_0003, "R4");
      wr(6, 32'd1);
      #8 chk("R8", {63'd0, irq}, 64'd1);
      @(posedge clk); #2;
      wr(7, 32'd1);
      #8 chk("R8", {63'd0, irq}, 64'd0);
      @(posedge clk); #2;
      idle(100);
      rdchk(7, 32'd0, "R6");
      rdchk(3, 32'd100, "R6");

      // R7: self-rearming comparator
      wr(2, 32'd0);
      wr(0, 32'd0); wr(1, 32'd0); wr(3, 32'd50); wr(5, 32'd40);
      wr(2, 32'd7);
      n_clr = 0;
      for (int i = 0; i < 300; i++) begin
         if (irq) begin wr(7, 32'd1); n_clr++; end
         else idle(1);
      end
      rd_addr = 3; #8 v = rd_data; @(posedge clk); #2;
      chk("R7", {63'd0, (v > 32'd50) && ((v - 32'd50) % 32'd40 == 0)}, 64'd1);
      chk("R7", {63'd0, n_clr >= 5}, 64'd1);
      rdchk(8, 32'h0001_0007, "R4");

      // R9: compare disabled, counter keeps running past the compare value
      wr(2, 32'd1);
      wr(6, 32'd0);
      idle(6);
      wr(7, 32'd1);
      idle(200);
      rdchk(7, 32'd0, "R9");
      chk("R9", {63'd0, irq}, 64'd0);

      idle(4);
      finish_run();
   end
endmodule